// File: doc/BRIEF.md
# SPI Transmit/Receive Queue Pair

This block holds the two data queues that sit between a serial peripheral controller's register file and its serial shifter. On the register side, a write strobe appends a word to the transmit queue and a read strobe takes the oldest word from the receive queue. On the shifter side, a pop strobe takes the next transmit word and a push strobe stores a freshly received word. Both queues hold 256 entries, one frame per entry. Frames narrower than the entry sit in the low-order bits.

Two level-driven interrupt requests tell software when to act. One fires while the transmit queue has fallen to or below its threshold. The other fires while the receive queue holds more entries than its threshold. Three sticky error flags record a write into a full transmit queue, a push into a full receive queue and a read from an empty receive queue. The flags stay set until a clear strobe arrives. Dropping the controller-enable input empties both queues.

Top module: `spi_queue_pair`

## Requirements
- R1: Reset, or any clock edge with `ctrlEnable` low, leaves both `txLevel` and `rxLevel` at 0. Writes, pops and pushes that arrive while `ctrlEnable` is low store nothing.
- R2: Each queue is first-in first-out and holds up to 256 words. `txLevel` and `rxLevel` report the exact occupancy, from 0 to 256. A read from a non-empty receive queue drives the oldest word on `regRdData` with `regRdValid` high in that same cycle.
- R3: `txEmptyIrq` is high exactly while `txLevel` is less than or equal to the registered transmit threshold.
- R4: `rxFullIrq` is high exactly while `rxLevel` is greater than or equal to the registered receive threshold plus one.
- R5: A register write into a full transmit queue sets `txOverflowErr`. The word is discarded and the level stays at 256.
- R6: A shifter push into a full receive queue sets `rxOverrunErr`. The word is dropped and the stored words and their order are unchanged.
- R7: A register read of an empty receive queue sets `rxUnderflowErr`. That read returns `regRdValid` low and `regRdData` zero.
- R8: A register write and a shifter pop in the same cycle on a full transmit queue both succeed without an error, and the same holds for a push and a read on a full receive queue. A push and a read in the same cycle on an empty receive queue stores the word and reports the read as an underflow. The word becomes readable from the next cycle.
- R9: The error flags stay set until `errClear` is high at a clock edge. If a flag is set and cleared in the same cycle, the set wins.
- R10: A new threshold value affects its interrupt output from the cycle after it is presented, and not in the cycle it is presented.
- R11: `frameBits` selects the frame width, and the value 0 or any value above 32 means full width. The transmit word offered on `shTxData` and each received word stored in the queue keep only the low `frameBits` bits, with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEnable | input | 1 | Controller enable; low empties both queues |
| frameBits | input | 6 | Frame width in bits (0 means full width) |
| txThresh | input | 8 | Transmit interrupt threshold |
| rxThresh | input | 8 | Receive interrupt threshold |
| regWrEn | input | 1 | Register-side write to the transmit queue |
| regWrData | input | 32 | Word written to the transmit queue |
| regRdEn | input | 1 | Register-side read from the receive queue |
| regRdData | output | 32 | Oldest receive word, zero when the read is invalid |
| regRdValid | output | 1 | The current read returns valid data |
| shTxPop | input | 1 | Shifter takes the next transmit word |
| shTxData | output | 32 | Next transmit word, masked to the frame width |
| shRxPush | input | 1 | Shifter delivers a received word |
| shRxData | input | 32 | Received word |
| txLevel | output | 9 | Transmit queue occupancy |
| rxLevel | output | 9 | Receive queue occupancy |
| txEmptyIrq | output | 1 | Transmit level at or below its threshold |
| rxFullIrq | output | 1 | Receive level above its threshold |
| txOverflowErr | output | 1 | Sticky: write into a full transmit queue |
| rxOverrunErr | output | 1 | Sticky: push into a full receive queue |
| rxUnderflowErr | output | 1 | Sticky: read from an empty receive queue |
| errClear | input | 1 | Clears all three error flags |

## Verification
The register-side access and the shifter-side access to the same queue can land in the same cycle, and the cases that matter are when that queue is full or empty. The bench fills the transmit queue to 256 and then writes and pops in one cycle. The level must stay at 256, no overflow may appear, and draining the queue must show the new word at the tail. It then does the same with a full receive queue, using a read and a push together. Finally it pushes into an empty receive queue while reading it. That read must come back invalid and raise the underflow flag, and the pushed word must be returned by the following read.

// File: rtl/spi_qp_pkg.sv
package spi_qp_pkg;

  // Strobes issued by the control unit to the queue storage.
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } qpStrobes_t;

endpackage

// File: rtl/spi_qp_store.sv
module spi_qp_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData
);

  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];

endmodule

// File: rtl/spi_qp_datapath.sv
module spi_qp_datapath
  import spi_qp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int FB_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  qpStrobes_t        st,
  input  logic [FB_W-1:0]   frameBits,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] shRxData,
  output logic [DATA_W-1:0] shTxData,
  output logic [DATA_W-1:0] regRdData
);

  logic [DATA_W-1:0] frameMask;
  logic [DATA_W-1:0] txHead;
  logic [DATA_W-1:0] rxHead;
  logic              fullWidth;

  assign fullWidth = (frameBits == '0) || (int'(frameBits) > DATA_W);

  // One mask bit per data bit: keep bit b only if it lies inside the frame.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign frameMask[b] = fullWidth || (int'(frameBits) > b);
  end

  spi_qp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txStore (
    .clk      (clk),
    .rstN     (rstN),
    .push     (st.txPush),
    .pop      (st.txPop),
    .flush    (st.flush),
    .wrData   (regWrData),
    .headData (txHead)
  );

  spi_qp_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxStore (
    .clk      (clk),
    .rstN     (rstN),
    .push     (st.rxPush),
    .pop      (st.rxPop),
    .flush    (st.flush),
    .wrData   (shRxData & frameMask),
    .headData (rxHead)
  );

  assign shTxData  = txHead & frameMask;
  assign regRdData = st.rxPop ? rxHead : '0;

endmodule

// File: rtl/spi_qp_control.sv
module spi_qp_control
  import spi_qp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int TH_W  = 8,
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlEnable,
  input  logic [TH_W-1:0]  txThresh,
  input  logic [TH_W-1:0]  rxThresh,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             shTxPop,
  input  logic             shRxPush,
  input  logic             errClear,
  output qpStrobes_t       st,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txEmptyIrq,
  output logic             rxFullIrq,
  output logic             txOverflowErr,
  output logic             rxOverrunErr,
  output logic             rxUnderflowErr
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] txCnt, rxCnt;
  logic [TH_W-1:0]  txThQ, rxThQ;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPopOk, txPushOk, rxPopOk, rxPushOk;
  logic setOverflow, setOverrun, setUnderflow;

  assign txFull  = (txCnt == FULL_LVL);
  assign txEmpty = (txCnt == '0);
  assign rxFull  = (rxCnt == FULL_LVL);
  assign rxEmpty = (rxCnt == '0);

  // A pop on a full queue frees the slot a same-cycle push needs.
  assign txPopOk  = ctrlEnable && shTxPop && !txEmpty;
  assign txPushOk = ctrlEnable && regWrEn && (!txFull || txPopOk);
  assign rxPopOk  = ctrlEnable && regRdEn && !rxEmpty;
  assign rxPushOk = ctrlEnable && shRxPush && (!rxFull || rxPopOk);

  assign setOverflow  = ctrlEnable && regWrEn && txFull && !txPopOk;
  assign setOverrun   = ctrlEnable && shRxPush && rxFull && !rxPopOk;
  assign setUnderflow = regRdEn && !rxPopOk;

  always_comb begin
    st        = '0;
    st.txPush = txPushOk;
    st.txPop  = txPopOk;
    st.rxPush = rxPushOk;
    st.rxPop  = rxPopOk;
    st.flush  = !ctrlEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else if (!ctrlEnable) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      txCnt <= txCnt + LVL_W'(txPushOk) - LVL_W'(txPopOk);
      rxCnt <= rxCnt + LVL_W'(rxPushOk) - LVL_W'(rxPopOk);
    end
  end

  // Thresholds are sampled every cycle; a change shows one cycle later.
  always_ff @(posedge clk) begin
    txThQ <= txThresh;
    rxThQ <= rxThresh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverflowErr  <= 1'b0;
      rxOverrunErr   <= 1'b0;
      rxUnderflowErr <= 1'b0;
    end else begin
      txOverflowErr  <= setOverflow  || (txOverflowErr  && !errClear);
      rxOverrunErr   <= setOverrun   || (rxOverrunErr   && !errClear);
      rxUnderflowErr <= setUnderflow || (rxUnderflowErr && !errClear);
    end
  end

  assign txLevel    = txCnt;
  assign rxLevel    = rxCnt;
  assign txEmptyIrq = ({1'b0, txCnt} <= (LVL_W + 1)'(txThQ));
  assign rxFullIrq  = ({1'b0, rxCnt} >= (LVL_W + 1)'(rxThQ) + 1'b1);

endmodule

// File: rtl/spi_queue_pair.sv
module spi_queue_pair
  import spi_qp_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 256,
  parameter  int TH_W   = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int FB_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic [FB_W-1:0]   frameBits,
  input  logic [TH_W-1:0]   txThresh,
  input  logic [TH_W-1:0]   rxThresh,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  input  logic              shTxPop,
  output logic [DATA_W-1:0] shTxData,
  input  logic              shRxPush,
  input  logic [DATA_W-1:0] shRxData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txEmptyIrq,
  output logic              rxFullIrq,
  output logic              txOverflowErr,
  output logic              rxOverrunErr,
  output logic              rxUnderflowErr,
  input  logic              errClear
);

  qpStrobes_t st;

  spi_qp_control #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W)) ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .ctrlEnable     (ctrlEnable),
    .txThresh       (txThresh),
    .rxThresh       (rxThresh),
    .regWrEn        (regWrEn),
    .regRdEn        (regRdEn),
    .shTxPop        (shTxPop),
    .shRxPush       (shRxPush),
    .errClear       (errClear),
    .st             (st),
    .txLevel        (txLevel),
    .rxLevel        (rxLevel),
    .txEmptyIrq     (txEmptyIrq),
    .rxFullIrq      (rxFullIrq),
    .txOverflowErr  (txOverflowErr),
    .rxOverrunErr   (rxOverrunErr),
    .rxUnderflowErr (rxUnderflowErr)
  );

  spi_qp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FB_W(FB_W)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .frameBits (frameBits),
    .regWrData (regWrData),
    .shRxData  (shRxData),
    .shTxData  (shTxData),
    .regRdData (regRdData)
  );

  assign regRdValid = st.rxPop;

endmodule

// File: rtl/spi_qp_checker.sv
module spi_qp_checker #(
  parameter int DEPTH = 256,
  parameter int TH_W  = 8,
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlEnable,
  input logic [TH_W-1:0]  txThresh,
  input logic [TH_W-1:0]  rxThresh,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic             regRdValid,
  input logic             shTxPop,
  input logic             shRxPush,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             txEmptyIrq,
  input logic             rxFullIrq,
  input logic             txOverflowErr,
  input logic             rxOverrunErr,
  input logic             rxUnderflowErr,
  input logic             errClear
);

  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlEnable) |-> (txLevel == '0 && rxLevel == '0));

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txLevel) <= DEPTH) && (int'(rxLevel) <= DEPTH));

  assert_tx_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq == (int'(txLevel) <= int'($past(txThresh))));

  assert_rx_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxFullIrq == (int'(rxLevel) >= int'($past(rxThresh)) + 1));

  assert_overflow_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOverflowErr) |-> ($past(regWrEn) && int'($past(txLevel)) == DEPTH));

  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrunErr) |-> ($past(shRxPush) && int'($past(rxLevel)) == DEPTH));

  assert_underflow_invalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && rxLevel == '0) |-> !regRdValid);

  assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEnable && regWrEn && shTxPop && int'(txLevel) == DEPTH) |=> int'(txLevel) == DEPTH);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txOverflowErr && !errClear) |=> txOverflowErr);

endmodule

bind spi_queue_pair spi_qp_checker #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W)) chk (
  .clk            (clk),
  .rstN           (rstN),
  .ctrlEnable     (ctrlEnable),
  .txThresh       (txThresh),
  .rxThresh       (rxThresh),
  .regWrEn        (regWrEn),
  .regRdEn        (regRdEn),
  .regRdValid     (regRdValid),
  .shTxPop        (shTxPop),
  .shRxPush       (shRxPush),
  .txLevel        (txLevel),
  .rxLevel        (rxLevel),
  .txEmptyIrq     (txEmptyIrq),
  .rxFullIrq      (rxFullIrq),
  .txOverflowErr  (txOverflowErr),
  .rxOverrunErr   (rxOverrunErr),
  .rxUnderflowErr (rxUnderflowErr),
  .errClear       (errClear)
);

// File: tb/tb_spi_queue_pair.sv
`timescale 1ns/1ps
module tb_spi_queue_pair;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctrlEnable;
  logic [5:0]  frameBits;
  logic [7:0]  txThresh, rxThresh;
  logic        regWrEn, regRdEn, shTxPop, shRxPush, errClear;
  logic [31:0] regWrData, shRxData, regRdData, shTxData;
  logic        regRdValid;
  logic [8:0]  txLevel, rxLevel;
  logic        txEmptyIrq, rxFullIrq, txOverflowErr, rxOverrunErr, rxUnderflowErr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_queue_pair dut (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .frameBits(frameBits),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .regRdValid(regRdValid),
    .shTxPop(shTxPop), .shTxData(shTxData), .shRxPush(shRxPush), .shRxData(shRxData),
    .txLevel(txLevel), .rxLevel(rxLevel), .txEmptyIrq(txEmptyIrq), .rxFullIrq(rxFullIrq),
    .txOverflowErr(txOverflowErr), .rxOverrunErr(rxOverrunErr),
    .rxUnderflowErr(rxUnderflowErr), .errClear(errClear)
  );

  // Vector: [42:41] op (0 write tx, 1 push rx, 2 read rx, 3 pop tx),
  //         [40:9] data written or expected, [8:0] level of that queue afterwards.
  localparam logic [42:0] VEC [8] = '{
    {2'd0, 32'h0000_00A1, 9'd1},
    {2'd0, 32'h0000_00B2, 9'd2},
    {2'd1, 32'h0000_00C3, 9'd1},
    {2'd3, 32'h0000_00A1, 9'd1},
    {2'd1, 32'h0000_00D4, 9'd2},
    {2'd2, 32'h0000_00C3, 9'd1},
    {2'd3, 32'h0000_00B2, 9'd0},
    {2'd2, 32'h0000_00D4, 9'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic txWrite(input logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rxPush(input logic [31:0] d);
    shRxPush = 1'b1; shRxData = d;
    tick();
    shRxPush = 1'b0;
  endtask

  task automatic rxRead(output logic [31:0] d, output logic v);
    regRdEn = 1'b1;
    #1 d = regRdData; v = regRdValid;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic txPop(output logic [31:0] d);
    shTxPop = 1'b1;
    #1 d = shTxData;
    tick();
    shTxPop = 1'b0;
  endtask

  task automatic flushAll();
    ctrlEnable = 1'b0;
    tick();
    ctrlEnable = 1'b1;
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    tick();
    errClear = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    int          bad;

    rstN = 1'b0; ctrlEnable = 1'b1; frameBits = 6'd32;
    txThresh = 8'd0; rxThresh = 8'd0;
    regWrEn = 1'b0; regRdEn = 1'b0; shTxPop = 1'b0; shRxPush = 1'b0; errClear = 1'b0;
    regWrData = '0; shRxData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1: state after reset
    check(txLevel == 0 && rxLevel == 0, "R1", "levels after reset", {txLevel, rxLevel}, 0);
    check(txEmptyIrq && !rxFullIrq, "R3", "irqs after reset", {txEmptyIrq, rxFullIrq}, 2);
    check({txOverflowErr, rxOverrunErr, rxUnderflowErr} == 0, "R9", "flags after reset",
          {txOverflowErr, rxOverrunErr, rxUnderflowErr}, 0);

    // R2: vector table of mixed queue traffic
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  op;
      logic [31:0] dat;
      logic [8:0]  lvl;
      op = VEC[i][42:41]; dat = VEC[i][40:9]; lvl = VEC[i][8:0];
      case (op)
        2'd0: begin txWrite(dat); check(txLevel == lvl, "R2", "tx level", txLevel, lvl); end
        2'd1: begin rxPush(dat);  check(rxLevel == lvl, "R2", "rx level", rxLevel, lvl); end
        2'd2: begin
          rxRead(d, v);
          check(v && d == dat, "R2", "rx read data", d, dat);
          check(rxLevel == lvl, "R2", "rx level", rxLevel, lvl);
        end
        default: begin
          txPop(d);
          check(d == dat, "R2", "tx pop data", d, dat);
          check(txLevel == lvl, "R2", "tx level", txLevel, lvl);
        end
      endcase
    end

    // R3: transmit threshold comparison
    txThresh = 8'd3; tick();
    for (int i = 0; i < 3; i++) txWrite(32'h10 + i);
    check(txEmptyIrq, "R3", "tx irq at level 3 thresh 3", txEmptyIrq, 1);
    txWrite(32'h13);
    check(!txEmptyIrq, "R3", "tx irq at level 4 thresh 3", txEmptyIrq, 0);

    // R10: threshold change is seen one cycle later
    txThresh = 8'd5;
    #1 check(!txEmptyIrq, "R10", "tx irq before threshold registered", txEmptyIrq, 0);
    tick();
    check(txEmptyIrq, "R10", "tx irq after threshold registered", txEmptyIrq, 1);

    // R1: disable empties queues; a write during the disable is dropped
    rxPush(32'h77);
    ctrlEnable = 1'b0; regWrEn = 1'b1; regWrData = 32'h99;
    tick();
    regWrEn = 1'b0; ctrlEnable = 1'b1;
    check(txLevel == 0 && rxLevel == 0, "R1", "levels after disable", {txLevel, rxLevel}, 0);
    tick();
    check(txLevel == 0, "R1", "write while disabled stored nothing", txLevel, 0);

    // R4: receive threshold comparison
    rxThresh = 8'd2; tick();
    rxPush(32'h1); rxPush(32'h2);
    check(!rxFullIrq, "R4", "rx irq at level 2 thresh 2", rxFullIrq, 0);
    rxPush(32'h3);
    check(rxFullIrq, "R4", "rx irq at level 3 thresh 2", rxFullIrq, 1);
    flushAll();
    txThresh = 8'd0; rxThresh = 8'd0;

    // R5: overflow of the transmit queue
    for (int i = 0; i < 256; i++) txWrite(32'(i));
    check(txLevel == 256 && !txOverflowErr, "R5", "tx full without error", txLevel, 256);
    txWrite(32'hDEAD);
    check(txOverflowErr, "R5", "overflow flag", txOverflowErr, 1);
    check(txLevel == 256, "R5", "level after overflow", txLevel, 256);
    tick();
    check(txOverflowErr, "R9", "overflow flag sticky", txOverflowErr, 1);
    clearErr();
    check(!txOverflowErr, "R9", "flag cleared", txOverflowErr, 0);

    // R8: write and pop together on a full transmit queue
    regWrEn = 1'b1; regWrData = 32'hBEEF; shTxPop = 1'b1;
    #1 d = shTxData;
    tick();
    regWrEn = 1'b0; shTxPop = 1'b0;
    check(d == 32'h0, "R8", "pop data on full swap", d, 0);
    check(txLevel == 256 && !txOverflowErr, "R8", "full swap level/no error", txLevel, 256);
    bad = 0;
    for (int i = 1; i < 256; i++) begin
      txPop(d);
      if (d != 32'(i)) bad++;
    end
    check(bad == 0, "R5", "stored order after discarded write", bad, 0);
    txPop(d);
    check(d == 32'hBEEF, "R8", "swapped word at tail", d, 32'hBEEF);

    // R6: overrun of the receive queue
    for (int i = 0; i < 256; i++) rxPush(32'h100 + i);
    rxPush(32'hDEAD);
    check(rxOverrunErr, "R6", "overrun flag", rxOverrunErr, 1);
    check(rxLevel == 256, "R6", "level after overrun", rxLevel, 256);
    clearErr();
    rxRead(d, v);
    check(v && d == 32'h100, "R6", "head unchanged by overrun", d, 32'h100);
    rxPush(32'h6000);
    // R8: read and push together on a full receive queue
    regRdEn = 1'b1; shRxPush = 1'b1; shRxData = 32'h7000;
    #1 d = regRdData; v = regRdValid;
    tick();
    regRdEn = 1'b0; shRxPush = 1'b0;
    check(v && d == 32'h101, "R8", "rx read on full swap", d, 32'h101);
    check(rxLevel == 256 && !rxOverrunErr, "R8", "rx full swap level/no error", rxLevel, 256);
    bad = 0;
    for (int i = 2; i < 256; i++) begin
      rxRead(d, v);
      if (!v || d != 32'h100 + 32'(i)) bad++;
    end
    check(bad == 0, "R6", "rx order after dropped push", bad, 0);
    rxRead(d, v);
    check(d == 32'h6000, "R6", "rx second to last", d, 32'h6000);
    rxRead(d, v);
    check(d == 32'h7000, "R8", "rx tail word", d, 32'h7000);

    // R7: underflow
    rxRead(d, v);
    check(!v && d == 0, "R7", "empty read invalid", {v, d[30:0]}, 0);
    check(rxUnderflowErr, "R7", "underflow flag", rxUnderflowErr, 1);
    clearErr();
    // R8: push and read together on an empty receive queue
    regRdEn = 1'b1; shRxPush = 1'b1; shRxData = 32'h42;
    #1 v = regRdValid;
    tick();
    regRdEn = 1'b0; shRxPush = 1'b0;
    check(!v && rxUnderflowErr, "R8", "read during push into empty", {v, rxUnderflowErr}, 1);
    check(rxLevel == 1, "R8", "pushed word kept", rxLevel, 1);
    rxRead(d, v);
    check(v && d == 32'h42, "R8", "word readable next cycle", d, 32'h42);

    // R9: set and clear in the same cycle, set wins
    clearErr();
    errClear = 1'b1;
    rxRead(d, v);
    errClear = 1'b0;
    check(rxUnderflowErr, "R9", "set wins over clear", rxUnderflowErr, 1);
    clearErr();

    // R11: frame width masking
    frameBits = 6'd8;
    txWrite(32'hABCD_1234);
    check(shTxData == 32'h34, "R11", "tx upper bits masked", shTxData, 32'h34);
    rxPush(32'h0000_FFFF);
    frameBits = 6'd32;
    rxRead(d, v);
    check(v && d == 32'hFF, "R11", "rx stored right-justified", d, 32'hFF);
    check(shTxData == 32'hABCD_1234, "R11", "full width restores tx word", shTxData, 32'hABCD_1234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule